// File: doc/BRIEF.md
# Valid-byte compaction unit

This block takes a word of eight byte lanes together with one valid bit per lane, and it can take a new word on every clock cycle. It moves every valid byte down into the lowest output lanes and keeps the bytes in their input order. The upper lanes that hold no packed byte are driven to zero. Along with the packed word, the block returns a valid mask in which the low bits are ones and the rest are zeros, and a count of the valid bytes. Lane 0 is bits [7:0] and is the first position.

Each input byte is sent to the output lane whose number equals the count of valid bytes in the lanes below it. The first register stage computes that rank for every byte. The second register stage uses the ranks to select a byte for each output lane. An input strobe passes through the same two stages, so the result of any input appears exactly two cycles after it. Words are never merged, no byte is held from one word to the next, and there is no backpressure.

Top module: `byte_compactor`

## Requirements
- R1: Every input byte whose valid bit is set appears in the output lane whose index equals the number of set valid bits in the lanes below it. The bytes therefore keep their input order and fill the output from lane 0 (bits [7:0]) upward.
- R2: Every output byte lane at or above the valid count is zero, whatever the content of the invalid input bytes.
- R3: `out_mask` has bit j set exactly when j is less than the valid count. It is a run of ones starting at bit 0.
- R4: `out_count` (4 bits) equals the number of set bits in the input mask, from 0 to 8.
- R5: `out_stb` equals `in_stb` delayed by exactly two clock cycles. The output data, mask and count are those of the input sampled two cycles earlier, whatever the strobe value.
- R6: When all eight valid bits are set, `out_data` equals `in_data`, `out_mask` is 8'hFF and the count is 8.
- R7: When no valid bit is set, `out_data`, `out_mask` and `out_count` are all zero.
- R8: A new input is accepted on every cycle. Back-to-back words with different masks each produce their own correct result on consecutive cycles.
- R9: While `rst` (synchronous, active high) is asserted, and on the first cycle after it is released, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_stb | input | 1 | Input word strobe, delayed along with the data |
| in_data | input | 64 | Eight input bytes, lane 0 at bits [7:0] |
| in_mask | input | 8 | One valid bit per input byte lane |
| out_stb | output | 1 | Strobe, two cycles after `in_stb` |
| out_data | output | 64 | Packed bytes, zero above the count |
| out_mask | output | 8 | Run of ones from bit 0, length equals count |
| out_count | output | 4 | Number of valid bytes, 0 to 8 |

## Verification
A wrong rank in the first stage sends a byte to the wrong lane, or makes two bytes collide in one lane. This shows up in `out_data` two cycles after the input that exposes it. Back-to-back masks with gaps in different places therefore check every rank position. If the filler is not cleared, stale or invalid input bytes show up above `out_count`. If the strobe, mask or count registers are out of step with the data, the two-cycle alignment breaks on the very first word of a stream.

// File: rtl/compact_pkg.sv
package compact_pkg;
  localparam int DEF_LANES  = 8;
  localparam int DEF_LANE_W = 8;
endpackage

// File: rtl/byte_rank.sv
module byte_rank #(
  parameter int LANES  = compact_pkg::DEF_LANES,
  parameter int LANE_W = compact_pkg::DEF_LANE_W,
  localparam int IW = $clog2(LANES),
  localparam int CW = $clog2(LANES + 1)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          in_stb,
  input  logic [LANES*LANE_W-1:0]       in_data,
  input  logic [LANES-1:0]              in_mask,
  output logic                          r_stb,
  output logic [LANES-1:0][LANE_W-1:0]  r_data,
  output logic [LANES-1:0]              r_mask,
  output logic [LANES-1:0][IW-1:0]      r_dest,
  output logic [CW-1:0]                 r_count
);
  logic [LANES-1:0][IW-1:0]     c_dest;
  logic [CW-1:0]                c_count;
  logic [LANES-1:0][LANE_W-1:0] c_data;

  // running prefix count: rank of each byte among the valid ones
  always_comb begin
    logic [CW-1:0] run;
    run = '0;
    for (int i = 0; i < LANES; i++) begin
      c_dest[i] = run[IW-1:0];
      c_data[i] = in_mask[i] ? in_data[i*LANE_W +: LANE_W] : '0;
      run = run + CW'(in_mask[i]);
    end
    c_count = run;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      r_stb   <= 1'b0;
      r_data  <= '0;
      r_mask  <= '0;
      r_dest  <= '0;
      r_count <= '0;
    end else begin
      r_stb   <= in_stb;
      r_data  <= c_data;
      r_mask  <= in_mask;
      r_dest  <= c_dest;
      r_count <= c_count;
    end
  end

  // R4: registered count matches the mask it came with
  p_count_pop_r4: assert property (@(posedge clk) disable iff (rst)
    32'(r_count) == $countones(r_mask));
endmodule

// File: rtl/lane_gather.sv
module lane_gather #(
  parameter int LANES  = compact_pkg::DEF_LANES,
  parameter int LANE_W = compact_pkg::DEF_LANE_W,
  localparam int IW = $clog2(LANES),
  localparam int CW = $clog2(LANES + 1)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          r_stb,
  input  logic [LANES-1:0][LANE_W-1:0]  r_data,
  input  logic [LANES-1:0]              r_mask,
  input  logic [LANES-1:0][IW-1:0]      r_dest,
  input  logic [CW-1:0]                 r_count,
  output logic                          out_stb,
  output logic [LANES*LANE_W-1:0]       out_data,
  output logic [LANES-1:0]              out_mask,
  output logic [CW-1:0]                 out_count
);
  logic [LANES-1:0][LANE_W-1:0] c_lane;
  logic [LANES-1:0]             c_mask;

  // each output lane ORs in the one byte whose rank names it
  always_comb begin
    for (int j = 0; j < LANES; j++) begin
      c_lane[j] = '0;
      for (int i = 0; i < LANES; i++) begin
        if (r_mask[i] && (r_dest[i] == IW'(j)))
          c_lane[j] = c_lane[j] | r_data[i];
      end
      c_mask[j] = (CW'(j) < r_count);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_stb   <= 1'b0;
      out_data  <= '0;
      out_mask  <= '0;
      out_count <= '0;
    end else begin
      out_stb   <= r_stb;
      out_data  <= c_lane;
      out_mask  <= c_mask;
      out_count <= r_count;
    end
  end

  // R2: lanes at or above the count carry zero
  for (genvar j = 0; j < LANES; j++) begin : g_fill_chk
    p_fill_zero_r2: assert property (@(posedge clk) disable iff (rst)
      (CW'(j) >= out_count) |-> (out_data[j*LANE_W +: LANE_W] == '0));
  end

  // R3: mask length equals count
  p_mask_len_r3: assert property (@(posedge clk) disable iff (rst)
    $countones(out_mask) == 32'(out_count));
endmodule

// File: rtl/byte_compactor.sv
module byte_compactor #(
  parameter int LANES  = compact_pkg::DEF_LANES,
  parameter int LANE_W = compact_pkg::DEF_LANE_W,
  localparam int IW = $clog2(LANES),
  localparam int CW = $clog2(LANES + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_stb,
  input  logic [LANES*LANE_W-1:0] in_data,
  input  logic [LANES-1:0]        in_mask,
  output logic                    out_stb,
  output logic [LANES*LANE_W-1:0] out_data,
  output logic [LANES-1:0]        out_mask,
  output logic [CW-1:0]           out_count
);
  logic                         r_stb;
  logic [LANES-1:0][LANE_W-1:0] r_data;
  logic [LANES-1:0]             r_mask;
  logic [LANES-1:0][IW-1:0]     r_dest;
  logic [CW-1:0]                r_count;

  byte_rank #(.LANES(LANES), .LANE_W(LANE_W)) u_rank (
    .clk(clk), .rst(rst), .in_stb(in_stb), .in_data(in_data),
    .in_mask(in_mask), .r_stb(r_stb), .r_data(r_data), .r_mask(r_mask),
    .r_dest(r_dest), .r_count(r_count));

  lane_gather #(.LANES(LANES), .LANE_W(LANE_W)) u_gather (
    .clk(clk), .rst(rst), .r_stb(r_stb), .r_data(r_data), .r_mask(r_mask),
    .r_dest(r_dest), .r_count(r_count), .out_stb(out_stb),
    .out_data(out_data), .out_mask(out_mask), .out_count(out_count));

  // R5: a strobe out needs a strobe in two cycles before
  p_stb_lat_r5: assert property (@(posedge clk) disable iff (rst)
    out_stb |-> $past(in_stb, 2));

  // R4: count follows the popcount of the mask two cycles back
  p_count_r4: assert property (@(posedge clk) disable iff (rst)
    out_stb |-> (32'(out_count) == $countones($past(in_mask, 2))));

  // R6: full mask passes the word through
  p_full_pass_r6: assert property (@(posedge clk) disable iff (rst)
    (out_stb && ($past(in_mask, 2) == '1)) |-> (out_data == $past(in_data, 2)));

  // R7: empty mask gives all zeros
  p_empty_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (out_stb && ($past(in_mask, 2) == '0)) |-> (out_data == '0 && out_mask == '0));
endmodule

// File: tb/test_byte_compactor.sv
module test_byte_compactor;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_stb;
  logic [63:0] in_data;
  logic [7:0]  in_mask;
  logic        out_stb;
  logic [63:0] out_data;
  logic [7:0]  out_mask;
  logic [3:0]  out_count;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  byte_compactor i_byte_compactor (
    .clk(clk), .rst(rst), .in_stb(in_stb), .in_data(in_data),
    .in_mask(in_mask), .out_stb(out_stb), .out_data(out_data),
    .out_mask(out_mask), .out_count(out_count));

  // expected bundle {stb, count, mask, data}
  function automatic logic [76:0] model(logic s, logic [63:0] d, logic [7:0] m);
    logic [63:0] pd = '0;
    logic [7:0]  pm = '0;
    int k = 0;
    for (int i = 0; i < 8; i++) begin
      if (m[i]) begin
        pd[k*8 +: 8] = d[i*8 +: 8];
        pm[k] = 1'b1;
        k++;
      end
    end
    return {s, 4'(k), pm, pd};
  endfunction

  task automatic check(string req, logic [76:0] exp);
    logic [76:0] got = {out_stb, out_count, out_mask, out_data};
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic one_word(string req, logic [63:0] d, logic [7:0] m);
    @(negedge clk);
    in_stb = 1'b1; in_data = d; in_mask = m;
    @(negedge clk);
    in_stb = 1'b0; in_data = 64'hA5A5_5A5A_F00F_0FF0; in_mask = 8'h00;
    @(negedge clk);
    check(req, model(1'b1, d, m));
  endtask

  task automatic t_reset;
    rst = 1'b1; in_stb = 1'b1; in_data = '1; in_mask = '1;
    repeat (3) @(negedge clk);
    check("R9 in reset", 77'd0);
    rst = 1'b0; in_stb = 1'b0; in_mask = '0;
    @(negedge clk);
    check("R9 after reset", 77'd0);
  endtask

  task automatic t_patterns;
    one_word("R1 gaps", 64'h5544_0033_0000_2211, 8'b1101_0011);
    one_word("R1 low gap", 64'h6655_4400_3322_1100, 8'b1110_1110);
    one_word("R2 junk in invalid", 64'hDEAD_BEEF_CAFE_F00D, 8'b0010_0100);
    one_word("R3 single top", 64'h7700_0000_0000_0000, 8'b1000_0000);
    one_word("R4 alternate", 64'h0102_0304_0506_0708, 8'b0101_0101);
    one_word("R6 all valid", 64'h8877_6655_4433_2211, 8'hFF);
    one_word("R7 none valid", 64'hFFFF_FFFF_FFFF_FFFF, 8'h00);
  endtask

  task automatic t_stream;
    logic [76:0] exp_q [0:1];
    logic [15:0] lfsr = 16'hACE1;
    @(negedge clk);
    for (int n = 0; n < 40; n++) begin
      if (n >= 2) check(n == 2 ? "R5 first of stream" : "R8 back-to-back", exp_q[0]);
      exp_q[0] = exp_q[1];
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      in_stb  = lfsr[0];
      in_mask = lfsr[15:8] ^ 8'(n);
      in_data = {lfsr, ~lfsr, lfsr ^ 16'(n * 97), 16'(n)};
      exp_q[1] = model(in_stb, in_data, in_mask);
      @(negedge clk);
    end
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_patterns();
    t_stream();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule